// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave for a Clock Generator

This block is the serial control path of a clock generator. A host on an SMBus-style two-wire bus reads and writes a small bank of byte-wide registers. Those registers set the output enables, the post-divider choice and the M and N loop-divider codes. Every transfer is indexed and carries a byte count.

A write transfer sends the register index, then the number of data bytes, then the data. A read transfer first sets the index with a write-addressed header. It then issues a repeated start with the read address. The slave answers with a byte count, taken from a programmable count register, and then that many register bytes.

The clock and data lines are sampled by a synchronous system clock. The slave only ever pulls the data line low. An output-enable pin gates the per-output enable bits to form the effective enables. Two strap pins set part of the bus address, so that four devices can share one bus.

Top module: `smbcfg_slave`

## Requirements
- R1: The 7-bit device address is binary 11011 followed by strap_hi_i and then strap_lo_i, with bit 0 of the address byte set to 1 for a read. A mismatching address gets no acknowledge, and the data line stays released until the next start or stop.
- R2: A matching write transfer sends the address, the index N, the count X and then X data bytes, and each byte is acknowledged. The data bytes go to registers N, N+1, … because the index increments after each byte.
- R3: Reset values are as follows. Register 0 is 0x03. Register 5 is 0x82, which gives post_div4_o=1 and m_code_o=2. Register 6 is 0x0A, so n_code_o=10. Register 7 is 0x07. Registers 3 and 4 are 0x00. Both output enables are set.
- R4: Register 1 reads {0, strap_hi_i, strap_lo_i, 00000} and register 2 reads 0x01. A write to either is acknowledged but has no effect.
- R5: A read goes: write address, index N, repeated start, read address. The slave then sends a count byte equal to register 7 bits 4:0, followed by that many bytes starting at index N. After that it releases the line, so the host reads 0xFF. A read address that is not preceded by an index in the same transaction is not acknowledged.
- R6: In register 7 only bits 4:0 are writable; bits 7:5 read as 0.
- R7: An index above 7 reads as 0x00. A write to such an index is acknowledged and discarded.
- R8: out_en_o[i] is oe_pin_i AND register 0 bit i, for i in {0,1}. When oe_pin_i is low, all effective enables are 0.
- R9: post_div4_o follows register 5 bit 7. m_code_o follows register 5 bits 3:0. n_code_o follows register 6 bits 5:0.
- R10: Data bytes beyond the count X of a write are not acknowledged and are not written.
- R11: A start in the middle of a transfer restarts address decoding, and a stop returns the slave to idle with the data line released.
- R12: The slave changes its data-line pull only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_hi_i | input | 1 | Upper address strap |
| strap_lo_i | input | 1 | Lower address strap |
| oe_pin_i | input | 1 | Global output enable |
| reg_en_o | output | 2 | Per-output enable bits from register 0 |
| out_en_o | output | 2 | Effective enables, gated by oe_pin_i |
| post_div4_o | output | 1 | Post-divider select, 1 selects divide by 4 |
| m_code_o | output | 4 | M divider code |
| n_code_o | output | 6 | N divider code |

## Verification
The table loop writes one byte each to a writable register, to both read-only registers, to an out-of-range index and to the count register, and reads each one back. This separates a plain store from masking, fixed values and discard. The multi-byte write and read checks show that the index increments and that the read stops after the programmed count, where the host then sees 0xFF. Further transfers check the following:
- overrun past the write count;
- a wrong address, and a read with no index set;
- a restart in the middle of a write;
- OE gating;
- the reset values after a second reset.

Together these separate acknowledge decisions from register effects.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;
  localparam int DW      = 8;
  localparam int NREG    = 8;
  localparam int IDXW    = 8;
  localparam int CNTW    = 5;
  localparam int MW      = 4;
  localparam int NW      = 6;
  localparam logic [4:0]    ADDR_PREFIX = 5'b11011;
  localparam logic [DW-1:0] ID_VALUE    = 8'h01;

  localparam int REG_EN    = 0;
  localparam int REG_STRAP = 1;
  localparam int REG_ID    = 2;
  localparam int REG_DIV   = 5;
  localparam int REG_NDIV  = 6;
  localparam int REG_CNT   = 7;

  typedef enum logic [2:0] {L_IDLE, L_RX, L_RXACK, L_TX, L_TXACK, L_SKIP} link_st_t;
  typedef enum logic [1:0] {P_ADDR, P_INDEX, P_COUNT, P_DATA} phase_t;

  function automatic logic [DW-1:0] reg_default(input int i);
    case (i)
      REG_EN:   return 8'h03;
      REG_DIV:  return 8'h82;
      REG_NDIV: return 8'h0A;
      REG_CNT:  return 8'h07;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_wmask(input int i);
    case (i)
      REG_STRAP, REG_ID: return 8'h00;
      REG_CNT:           return 8'h1F;
      default:           return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/smbcfg_sync.sv
module smbcfg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] q_prev_o
);
  localparam int CW = WIDTH * (STAGES + 1);
  logic [CW-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[CW-WIDTH-1:0], d_i};
  end

  assign q_o      = chain[WIDTH*(STAGES-1) +: WIDTH];
  assign q_prev_o = chain[WIDTH*STAGES +: WIDTH];
endmodule

// File: rtl/smbcfg_regs.sv
module smbcfg_regs
  import smbcfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         strap_i,
  input  logic               wr_en_i,
  input  logic [IDXW-1:0]    wr_idx_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic [IDXW-1:0]    rd_idx_i,
  output logic [DW-1:0]      rd_data_o,
  output logic [NREG*DW-1:0] regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == REG_STRAP) begin : g_strap
      assign regs_o[i*DW +: DW] = {1'b0, strap_i, 5'b0};
    end else if (i == REG_ID) begin : g_id
      assign regs_o[i*DW +: DW] = ID_VALUE;
    end else begin : g_rw
      localparam logic [DW-1:0] MASK = reg_wmask(i);
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= reg_default(i);
        else if (wr_en_i && wr_idx_i == IDXW'(i))
          q <= (q & ~MASK) | (wr_data_i & MASK);
      end
      assign regs_o[i*DW +: DW] = q;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NREG; k++)
      if (rd_idx_i == IDXW'(k)) rd_data_o = regs_o[k*DW +: DW];
  end
endmodule

// File: rtl/smbcfg_link.sv
module smbcfg_link
  import smbcfg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_s,
  input  logic            scl_p,
  input  logic            sda_s,
  input  logic            sda_p,
  input  logic [1:0]      strap_i,
  input  logic [DW-1:0]   rd_data_i,
  input  logic [CNTW-1:0] cnt_i,
  output logic [IDXW-1:0] idx_o,
  output logic            wr_en_o,
  output logic [IDXW-1:0] wr_idx_o,
  output logic [DW-1:0]   wr_data_o,
  output logic            pull_o,
  output logic            idle_o,
  output logic            skip_o
);
  link_st_t        st;
  phase_t          ph;
  logic [DW-1:0]   sh;
  logic [3:0]      bitc;
  logic [IDXW-1:0] idx;
  logic            idx_ok, rd_mode, mack;
  logic [DW-1:0]   wrem;
  logic [CNTW-1:0] rrem;

  logic scl_rise, scl_fall, start_det, stop_det, addr_hit;
  logic [DW-1:0] cnt_byte;

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign addr_hit  = (sh[DW-1:1] == {ADDR_PREFIX, strap_i});
  assign cnt_byte  = DW'(cnt_i);

  always_ff @(posedge clk) begin
    wr_en_o <= 1'b0;
    if (rst) begin
      st <= L_IDLE; ph <= P_ADDR; sh <= '0; bitc <= '0; idx <= '0;
      idx_ok <= 1'b0; rd_mode <= 1'b0; mack <= 1'b0; wrem <= '0; rrem <= '0;
      pull_o <= 1'b0; wr_idx_o <= '0; wr_data_o <= '0;
    end else if (start_det) begin
      st <= L_RX; ph <= P_ADDR; bitc <= '0; pull_o <= 1'b0; rd_mode <= 1'b0;
    end else if (stop_det) begin
      st <= L_IDLE; pull_o <= 1'b0; idx_ok <= 1'b0;
    end else begin
      unique case (st)
        L_RX: begin
          if (scl_rise) begin
            sh   <= {sh[DW-2:0], sda_s};
            bitc <= bitc + 4'd1;
          end else if (scl_fall && bitc == 4'(DW)) begin
            bitc   <= '0;
            st     <= L_SKIP;
            pull_o <= 1'b0;
            unique case (ph)
              P_ADDR: if (addr_hit && (!sh[0] || idx_ok)) begin
                st <= L_RXACK; pull_o <= 1'b1; rd_mode <= sh[0]; ph <= P_INDEX;
              end
              P_INDEX: begin
                idx <= sh; idx_ok <= 1'b1; ph <= P_COUNT;
                st <= L_RXACK; pull_o <= 1'b1;
              end
              P_COUNT: begin
                wrem <= sh; ph <= P_DATA;
                st <= L_RXACK; pull_o <= 1'b1;
              end
              P_DATA: if (wrem != '0) begin
                wr_en_o <= 1'b1; wr_idx_o <= idx; wr_data_o <= sh;
                idx <= idx + 1'b1; wrem <= wrem - 1'b1;
                st <= L_RXACK; pull_o <= 1'b1;
              end
              default: ;
            endcase
          end
        end
        L_RXACK: if (scl_fall) begin
          bitc <= '0;
          if (rd_mode) begin
            st <= L_TX; sh <= cnt_byte; rrem <= cnt_i; pull_o <= ~cnt_byte[DW-1];
          end else begin
            st <= L_RX; pull_o <= 1'b0;
          end
        end
        L_TX: if (scl_fall) begin
          if (bitc == 4'(DW-1)) begin
            st <= L_TXACK; pull_o <= 1'b0;
          end else begin
            sh <= {sh[DW-2:0], 1'b0}; pull_o <= ~sh[DW-2]; bitc <= bitc + 4'd1;
          end
        end
        L_TXACK: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            if (mack && rrem != '0) begin
              sh <= rd_data_i; pull_o <= ~rd_data_i[DW-1];
              idx <= idx + 1'b1; rrem <= rrem - 1'b1; bitc <= '0; st <= L_TX;
            end else begin
              st <= L_SKIP; pull_o <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign idx_o  = idx;
  assign idle_o = (st == L_IDLE);
  assign skip_o = (st == L_SKIP);
endmodule

// File: rtl/smbcfg_slave.sv
module smbcfg_slave
  import smbcfg_pkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic               strap_hi_i,
  input  logic               strap_lo_i,
  input  logic               oe_pin_i,
  output logic [NUM_OUT-1:0] reg_en_o,
  output logic [NUM_OUT-1:0] out_en_o,
  output logic               post_div4_o,
  output logic [MW-1:0]      m_code_o,
  output logic [NW-1:0]      n_code_o
);
  logic [1:0] line_s, line_p;
  logic [IDXW-1:0] rd_idx, wr_idx;
  logic [DW-1:0] rd_data, wr_data;
  logic wr_en, link_idle, link_skip;
  logic [NREG*DW-1:0] regs;
  logic [DW-1:0] r_en, r_div, r_ndiv, r_cnt;

  smbcfg_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d_i({scl_i, sda_i}), .q_o(line_s), .q_prev_o(line_p)
  );

  smbcfg_link u_link (
    .clk(clk), .rst(rst),
    .scl_s(line_s[1]), .scl_p(line_p[1]), .sda_s(line_s[0]), .sda_p(line_p[0]),
    .strap_i({strap_hi_i, strap_lo_i}), .rd_data_i(rd_data), .cnt_i(r_cnt[CNTW-1:0]),
    .idx_o(rd_idx), .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .pull_o(sda_pull_o), .idle_o(link_idle), .skip_o(link_skip)
  );

  smbcfg_regs u_regs (
    .clk(clk), .rst(rst), .strap_i({strap_hi_i, strap_lo_i}),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .regs_o(regs)
  );

  assign r_en   = regs[REG_EN*DW +: DW];
  assign r_div  = regs[REG_DIV*DW +: DW];
  assign r_ndiv = regs[REG_NDIV*DW +: DW];
  assign r_cnt  = regs[REG_CNT*DW +: DW];

  assign reg_en_o    = r_en[NUM_OUT-1:0];
  assign post_div4_o = r_div[DW-1];
  assign m_code_o    = r_div[MW-1:0];
  assign n_code_o    = r_ndiv[NW-1:0];

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_oe
    always_ff @(posedge clk) begin
      if (rst) out_en_o[g] <= 1'b0;
      else     out_en_o[g] <= oe_pin_i & r_en[g];
    end
  end

  logic unused_bits;
  assign unused_bits = ^{r_en[DW-1:NUM_OUT], r_div[DW-2:MW], r_ndiv[DW-1:NW],
                         r_cnt[DW-1:CNTW], regs[3*DW +: 2*DW], regs[REG_STRAP*DW +: 2*DW],
                         link_idle, link_skip};
endmodule

// File: rtl/smbcfg_chk.sv
module smbcfg_chk
  import smbcfg_pkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               scl_i,
  input logic               oe_pin_i,
  input logic               sda_pull_o,
  input logic               link_idle,
  input logic               link_skip,
  input logic [NUM_OUT-1:0] reg_en_o,
  input logic [NUM_OUT-1:0] out_en_o,
  input logic               post_div4_o,
  input logic [MW-1:0]      m_code_o,
  input logic [NW-1:0]      n_code_o
);
  localparam logic [DW-1:0] DIV_RST  = reg_default(REG_DIV);
  localparam logic [DW-1:0] NDIV_RST = reg_default(REG_NDIV);

  assert_pull_scl_low_R12: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3)) |-> $stable(sda_pull_o));

  assert_oe_low_off_R8: assert property (@(posedge clk) disable iff (rst)
    !oe_pin_i |=> (out_en_o == '0));

  assert_reg_off_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_en_o == '0) |=> (out_en_o == '0));

  assert_reset_vals_R3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (post_div4_o == DIV_RST[DW-1] && m_code_o == DIV_RST[MW-1:0]
                    && n_code_o == NDIV_RST[NW-1:0]));

  assert_idle_release_R11: assert property (@(posedge clk) disable iff (rst)
    link_idle |-> !sda_pull_o);

  assert_skip_release_R1: assert property (@(posedge clk) disable iff (rst)
    link_skip |-> !sda_pull_o);
endmodule

bind smbcfg_slave smbcfg_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .oe_pin_i(oe_pin_i), .sda_pull_o(sda_pull_o),
  .link_idle(link_idle), .link_skip(link_skip), .reg_en_o(reg_en_o), .out_en_o(out_en_o),
  .post_div4_o(post_div4_o), .m_code_o(m_code_o), .n_code_o(n_code_o)
);

// File: tb/test_smbcfg_slave.sv
module test_smbcfg_slave;
  localparam int HP = 20;
  localparam int Q  = 4;
  localparam logic [7:0] WRA = 8'hDC;
  localparam logic [7:0] RDA = 8'hDD;

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, m_pull = 1'b0;
  logic as2 = 1'b1, as1 = 1'b0, oe = 1'b1;
  logic sda, s_pull, post;
  logic [1:0] reg_en, out_en;
  logic [3:0] mc;
  logic [5:0] nc;
  int n_chk = 0, n_err = 0;
  logic ackv [8];
  logic [7:0] rb [8];
  logic [7:0] rcount;

  assign sda = !(m_pull || s_pull);
  always #5 clk = ~clk;

  smbcfg_slave i_smbcfg_slave (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .sda_pull_o(s_pull),
    .strap_hi_i(as2), .strap_lo_i(as1), .oe_pin_i(oe), .reg_en_o(reg_en),
    .out_en_o(out_en), .post_div4_o(post), .m_code_o(mc), .n_code_o(nc)
  );

  // index, write data, expected read-back
  localparam logic [23:0] VEC [8] = '{
    {8'h05, 8'h84, 8'h84},   // R2 R9
    {8'h06, 8'h13, 8'h13},   // R2
    {8'h01, 8'hFF, 8'h40},   // R4 strap register
    {8'h02, 8'h55, 8'h01},   // R4 id register
    {8'h09, 8'hAA, 8'h00},   // R7 out of range
    {8'h03, 8'hA5, 8'hA5},   // R2
    {8'h00, 8'h01, 8'h01},   // R8 enable bits
    {8'h07, 8'hE3, 8'h03}    // R6 count mask
  };

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    m_pull = 1'b0; cyc(HP); scl = 1'b1; cyc(HP); m_pull = 1'b1; cyc(HP); scl = 1'b0; cyc(Q);
  endtask

  task automatic bus_stop;
    m_pull = 1'b1; cyc(HP); scl = 1'b1; cyc(HP); m_pull = 1'b0; cyc(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_pull = !b[i]; cyc(HP - Q); scl = 1'b1; cyc(HP); scl = 1'b0; cyc(Q);
    end
    m_pull = 1'b0; cyc(HP - Q); scl = 1'b1; cyc(HP / 2); ack = !sda;
    cyc(HP / 2); scl = 1'b0; cyc(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_pull = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      cyc(HP - Q); scl = 1'b1; cyc(HP / 2); b[i] = sda; cyc(HP / 2); scl = 1'b0; cyc(Q);
    end
    m_pull = give_ack; cyc(HP - Q); scl = 1'b1; cyc(HP); scl = 1'b0; cyc(Q); m_pull = 1'b0;
  endtask

  task automatic wr_xfer(input logic [7:0] addr, input logic [7:0] idx, input logic [7:0] cnt,
                         input int nsend, input logic [7:0] d0, input logic [7:0] d1,
                         input logic [7:0] d2);
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    bus_start;
    send_byte(addr, ackv[0]);
    send_byte(idx, ackv[1]);
    send_byte(cnt, ackv[2]);
    for (int k = 0; k < nsend; k++) send_byte(d[k], ackv[3 + k]);
    bus_stop;
  endtask

  task automatic rd_xfer(input logic [7:0] idx, input int n);
    bus_start;
    send_byte(WRA, ackv[0]);
    send_byte(idx, ackv[1]);
    bus_start;
    send_byte(RDA, ackv[2]);
    recv_byte(n > 0, rcount);
    for (int k = 0; k < n; k++) recv_byte(k < n - 1, rb[k]);
    bus_stop;
  endtask

  initial begin
    logic a;
    cyc(5); rst = 1'b0; cyc(4);
    // R3 reset state
    check("R3 post_div", int'(post), 1);
    check("R3 m_code", int'(mc), 2);
    check("R3 n_code", int'(nc), 10);
    check("R3 reg_en", int'(reg_en), 3);
    check("R3/R8 out_en", int'(out_en), 3);
    check("R12 released", int'(s_pull), 0);

    for (int v = 0; v < 8; v++) begin
      wr_xfer(WRA, VEC[v][23:16], 8'd1, 1, VEC[v][15:8], 8'h00, 8'h00);
      check("R1/R2 write acks", int'({ackv[0], ackv[1], ackv[2], ackv[3]}), 15);
      rd_xfer(VEC[v][23:16], 1);
      check("R2/R4/R6/R7 table readback", int'(rb[0]), int'(VEC[v][7:0]));
    end

    // R9 divider outputs, R8 gating
    check("R9 post_div", int'(post), 1);
    check("R9 m_code", int'(mc), 4);
    check("R9 n_code", int'(nc), 8'h13);
    check("R8 reg_en", int'(reg_en), 1);
    check("R8 out_en", int'(out_en), 1);
    oe = 1'b0; cyc(4);
    check("R8 oe low", int'(out_en), 0);
    oe = 1'b1; cyc(4);
    check("R8 oe high", int'(out_en), 1);

    // R2 multi-byte write with index increment
    wr_xfer(WRA, 8'h04, 8'd3, 3, 8'h5A, 8'h02, 8'h2C);
    check("R2 multi acks", int'({ackv[3], ackv[4], ackv[5]}), 7);
    check("R2/R9 post_div", int'(post), 0);
    check("R2/R9 m_code", int'(mc), 2);
    check("R2/R9 n_code", int'(nc), 8'h2C);

    // R5 block read with programmed count 3, then host reads past the end
    rd_xfer(8'h03, 4);
    check("R5 read acks", int'({ackv[0], ackv[1], ackv[2]}), 7);
    check("R5/R6 count byte", int'(rcount), 3);
    check("R5 byte0", int'(rb[0]), 8'hA5);
    check("R5 byte1", int'(rb[1]), 8'h5A);
    check("R5 byte2", int'(rb[2]), 8'h02);
    check("R5 past count", int'(rb[3]), 8'hFF);

    // R10 bytes beyond count
    wr_xfer(WRA, 8'h03, 8'd1, 2, 8'h11, 8'h22, 8'h00);
    check("R10 in-count ack", int'(ackv[3]), 1);
    check("R10 overrun nack", int'(ackv[4]), 0);
    rd_xfer(8'h03, 2);
    check("R10 reg3", int'(rb[0]), 8'h11);
    check("R10 reg4 untouched", int'(rb[1]), 8'h5A);

    // R1 wrong address
    wr_xfer(8'hD8, 8'h05, 8'd1, 1, 8'h8F, 8'h00, 8'h00);
    check("R1 mismatch nack", int'({ackv[0], ackv[1], ackv[2], ackv[3]}), 0);
    check("R1 no write", int'(mc), 2);
    // R5 read address without index
    bus_start; send_byte(RDA, a); bus_stop;
    check("R5 read without index nack", int'(a), 0);

    // R11 restart in the middle of a write
    bus_start;
    send_byte(WRA, ackv[0]); send_byte(8'h06, ackv[1]);
    send_byte(8'd2, ackv[2]); send_byte(8'h20, ackv[3]);
    bus_start;
    send_byte(8'hD8, ackv[4]); send_byte(8'h30, ackv[5]);
    bus_stop;
    check("R11 first byte acked", int'(ackv[3]), 1);
    check("R11 restart mismatch nack", int'({ackv[4], ackv[5]}), 0);
    check("R11 n_code", int'(nc), 8'h20);
    check("R11 released after stop", int'(s_pull), 0);

    // R3 second reset
    rst = 1'b1; cyc(4); rst = 1'b0; cyc(4);
    check("R3 post_div again", int'(post), 1);
    check("R3 m_code again", int'(mc), 2);
    check("R3 n_code again", int'(nc), 10);
    check("R3 out_en again", int'(out_en), 3);
    rd_xfer(8'h00, 5);
    check("R3 count default", int'(rcount), 7);
    check("R3 reg0", int'(rb[0]), 3);
    check("R4 strap reg", int'(rb[1]), 8'h40);
    check("R4 id reg", int'(rb[2]), 1);
    check("R3 reg3", int'(rb[3]), 0);
    check("R3 reg4", int'(rb[4]), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R2 watchdog: actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule